// File: doc/BRIEF.md
# Burst Master Engine

This block runs one burst on a memory-mapped bus for each command it accepts. A command gives a start address, a beat count and a direction. The engine puts the address and the beat count on the bus once, with the read or write request, and keeps them steady until the burst ends. It obeys the slave's wait signal and counts beats until the requested number has moved.

For a write, the data comes from a local valid/ready source. The engine takes one word into an output register whenever that register is empty or its current beat is being accepted. If the source has nothing ready, the engine drops the bus write strobe for that cycle instead of stalling. For a read, the engine holds the request until the slave accepts it. It then forwards each returned beat, one cycle later, on a local valid output. A single-cycle done pulse marks the end of every burst.

Top module: `burst_master`

## Requirements
- R1: After reset, cmd_ready is 1 and m_read, m_write, done and rd_valid are all 0.
- R2: A legal command is accepted in a cycle where cmd_valid and cmd_ready are both 1. From the next cycle, m_address and m_burstcount equal the command's address and length and stay fixed for the whole burst. cmd_ready stays 0 from acceptance until the cycle that carries done.
- R3: While m_waitrequest is 1, a pending request holds. On the next cycle m_read or m_write is still set, and m_address, m_burstcount and m_writedata are unchanged.
- R4: A write burst places local words on the bus in the order the source handed them over. wr_ready is 0 while a beat is waiting on m_waitrequest. Exactly cmd_len beats are accepted, where a beat is accepted in a cycle with m_write=1 and m_waitrequest=0.
- R5: If the output slot is free in a cycle (m_write=0 or m_waitrequest=0) and wr_valid is 0, m_write is 0 in the next cycle. The burst then continues when data arrives.
- R6: m_byteenable has every bit set in any cycle where m_read or m_write is 1.
- R7: done is 1 for exactly one cycle, the cycle after the final beat is accepted (write) or received (read).
- R8: m_read stays 1 until the cycle it is accepted and is 0 from then on. m_read and m_write are never both 1. Each cycle with m_readdatavalid=1 during the read data phase gives rd_valid=1 one cycle later, with rd_data equal to that m_readdata.
- R9: m_readdatavalid is ignored outside a read data phase, and rd_valid stays 0.
- R10: A command with length 0, or with a length above 2^(BCNT_W-1), is consumed with no bus request and no done pulse.
- R11: The longest burst, 2^(BCNT_W-1) beats, is requested with only the top bit of m_burstcount set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_addr | input | ADDR_W | Burst start address |
| cmd_len | input | BCNT_W | Beats in the burst |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| wr_valid | input | 1 | Local write word present |
| wr_ready | output | 1 | Engine takes the local write word this cycle |
| wr_data | input | DATA_W | Local write word |
| rd_valid | output | 1 | Returned read word present |
| rd_data | output | DATA_W | Returned read word |
| done | output | 1 | One-cycle burst completion pulse |
| m_address | output | ADDR_W | Bus address |
| m_burstcount | output | BCNT_W | Bus beat count |
| m_read | output | 1 | Bus read request |
| m_write | output | 1 | Bus write strobe |
| m_writedata | output | DATA_W | Bus write data |
| m_byteenable | output | DATA_W/8 | Bus byte lanes |
| m_waitrequest | input | 1 | Slave stall |
| m_readdata | input | DATA_W | Slave read data |
| m_readdatavalid | input | 1 | Slave read data valid |

## Verification
The bench builds the engine with a 4-bit beat count, a 12-bit address and 16-bit data. With a maximum burst of 8 beats, random bursts often reach the full length. The illegal lengths 0 and 9 sit right next to the legal range, and the single-top-bit encoding of the longest burst shows up without long runs. The short bursts keep stall and gap patterns dense, so holds under wait, write gaps and back-to-back read beats all occur many times in each run.

// File: rtl/bm_pkg.sv
// Shared types for the burst master engine.
package bm_pkg;
    // Engine phase: idle, streaming write beats, read request, read data return
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_RADDR = 2'd2,
        ST_RDATA = 2'd3
    } bm_state_t;
endpackage

// File: rtl/bm_beat_counter.sv
// Down-counter of beats still outstanding in a burst.
// Assumes load and step never occur in the same cycle.
module bm_beat_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    input  logic             step,
    output logic [CNT_W-1:0] remaining
);
    // Load the burst length, then count down once per beat
    always_ff @(posedge clk) begin
        if (!rst_n)
            remaining <= '0;
        else if (load)
            remaining <= len;
        else if (step && remaining != '0)
            remaining <= remaining - CNT_W'(1);
    end
endmodule

// File: rtl/bm_write_slot.sv
// Registered write-beat slot. It holds strobe and data steady while the bus stalls.
// The slot refills from the local source when it is empty or its beat is taken.
// Assumes 'more' drops to 0 once every beat of the burst has been loaded.
module bm_write_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              more,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    input  logic              bus_wait,
    output logic              src_ready,
    output logic              take,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_data
);
    logic slot_free;

    // The slot may change only when it is empty or its beat is accepted
    always_comb begin
        slot_free = !bus_write || !bus_wait;
        src_ready = active && more && slot_free;
        take      = src_ready && src_valid;
    end

    // Refill or empty the slot; a missing source word leaves a gap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_write <= 1'b0;
            bus_data  <= '0;
        end else if (slot_free) begin
            bus_write <= take;
            if (take)
                bus_data <= src_data;
        end
    end
endmodule

// File: rtl/bm_read_capture.sv
// Captures returned read beats in the cycle they are valid.
// Beats outside the read data phase are dropped.
module bm_read_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase,
    input  logic              bus_valid,
    input  logic [DATA_W-1:0] bus_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    // Register each valid beat seen during the data phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= phase && bus_valid;
            if (phase && bus_valid)
                out_data <= bus_data;
        end
    end
endmodule

// File: rtl/burst_master.sv
// Burst master engine: one read or write burst per accepted command.
// Address and beat count are issued once and held for the burst.
// Assumes DATA_W is a multiple of 8 and BCNT_W is between 2 and 32.
module burst_master #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int BCNT_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic [BCNT_W-1:0]     cmd_len,
    input  logic                  cmd_write,
    input  logic                  wr_valid,
    output logic                  wr_ready,
    input  logic [DATA_W-1:0]     wr_data,
    output logic                  rd_valid,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  done,
    output logic [ADDR_W-1:0]     m_address,
    output logic [BCNT_W-1:0]     m_burstcount,
    output logic                  m_read,
    output logic                  m_write,
    output logic [DATA_W-1:0]     m_writedata,
    output logic [DATA_W/8-1:0]   m_byteenable,
    input  logic                  m_waitrequest,
    input  logic [DATA_W-1:0]     m_readdata,
    input  logic                  m_readdatavalid
);
    import bm_pkg::*;

    localparam int               BE_W    = DATA_W / 8;
    localparam logic [BCNT_W-1:0] MAX_LEN = {1'b1, {(BCNT_W-1){1'b0}}};

    bm_state_t         state;
    logic              len_ok, start, ack_step, ack_last, load_more, take;
    logic [BCNT_W-1:0] ack_rem, load_rem;

    // Command acceptance and beat bookkeeping
    always_comb begin
        cmd_ready    = (state == ST_IDLE);
        len_ok       = (cmd_len != '0) && (cmd_len <= MAX_LEN);
        start        = cmd_valid && cmd_ready && len_ok;
        ack_step     = ((state == ST_WRITE) && m_write && !m_waitrequest) ||
                       ((state == ST_RDATA) && m_readdatavalid);
        ack_last     = ack_step && (ack_rem == BCNT_W'(1));
        load_more    = (load_rem != '0);
        m_byteenable = (state != ST_IDLE) ? {BE_W{1'b1}} : {BE_W{1'b0}};
    end

    // Beats still to complete on the bus
    bm_beat_counter #(.CNT_W(BCNT_W)) u_ack (
        .clk(clk), .rst_n(rst_n), .load(start), .len(cmd_len),
        .step(ack_step), .remaining(ack_rem)
    );

    // Write words still to take from the local source
    bm_beat_counter #(.CNT_W(BCNT_W)) u_load (
        .clk(clk), .rst_n(rst_n), .load(start && cmd_write), .len(cmd_len),
        .step(take), .remaining(load_rem)
    );

    bm_write_slot #(.DATA_W(DATA_W)) u_wslot (
        .clk(clk), .rst_n(rst_n), .active(state == ST_WRITE), .more(load_more),
        .src_valid(wr_valid), .src_data(wr_data), .bus_wait(m_waitrequest),
        .src_ready(wr_ready), .take(take), .bus_write(m_write), .bus_data(m_writedata)
    );

    bm_read_capture #(.DATA_W(DATA_W)) u_rcap (
        .clk(clk), .rst_n(rst_n), .phase(state == ST_RDATA),
        .bus_valid(m_readdatavalid), .bus_data(m_readdata),
        .out_valid(rd_valid), .out_data(rd_data)
    );

    // Phase sequencing, request registers and the completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            m_address    <= '0;
            m_burstcount <= '0;
            m_read       <= 1'b0;
            done         <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        m_address    <= cmd_addr;
                        m_burstcount <= cmd_len;
                        m_read       <= !cmd_write;
                        state        <= cmd_write ? ST_WRITE : ST_RADDR;
                    end
                end
                ST_WRITE: begin
                    if (ack_last) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                ST_RADDR: begin
                    if (!m_waitrequest) begin
                        m_read <= 1'b0;
                        state  <= ST_RDATA;
                    end
                end
                ST_RDATA: begin
                    if (ack_last) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bm_checker.sv
// Protocol checker for burst_master, attached by bind below.
module bm_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int BCNT_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_ready,
    input logic                done,
    input logic                rd_valid,
    input logic                m_read,
    input logic                m_write,
    input logic                m_waitrequest,
    input logic [ADDR_W-1:0]   m_address,
    input logic [BCNT_W-1:0]   m_burstcount,
    input logic [DATA_W-1:0]   m_writedata,
    input logic [DATA_W/8-1:0] m_byteenable
);
    localparam logic [BCNT_W-1:0] LIM = {1'b1, {(BCNT_W-1){1'b0}}};

    p_hold_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_write && m_waitrequest) |=> (m_write && $stable(m_writedata) &&
                                         $stable(m_address) && $stable(m_burstcount)));

    p_hold_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_read && m_waitrequest) |=> (m_read && $stable(m_address) && $stable(m_burstcount)));

    p_fixed_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> (cmd_ready || ($stable(m_address) && $stable(m_burstcount))));

    p_lanes_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_read || m_write) |-> (m_byteenable == {(DATA_W/8){1'b1}}));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_len_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_read || m_write) |-> (m_burstcount != '0 && m_burstcount <= LIM));

    p_no_stray_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && !done) |-> !rd_valid);

    p_one_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_read && m_write));
endmodule

bind burst_master bm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BCNT_W(BCNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .done(done), .rd_valid(rd_valid),
    .m_read(m_read), .m_write(m_write), .m_waitrequest(m_waitrequest),
    .m_address(m_address), .m_burstcount(m_burstcount), .m_writedata(m_writedata),
    .m_byteenable(m_byteenable)
);

// File: tb/sim_burst_master.sv
// Bench for burst_master: directed corners plus seeded random bursts.
module sim_burst_master;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [BW-1:0] cmd_len = '0;
    logic          cmd_ready, wr_ready, rd_valid, done, m_read, m_write;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0, rd_data, m_writedata;
    logic [DW-1:0] m_readdata = '0;
    logic          m_waitrequest = 1'b0, m_readdatavalid = 1'b0;
    logic [AW-1:0] m_address;
    logic [BW-1:0] m_burstcount;
    logic [DW/8-1:0] m_byteenable;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    burst_master #(.ADDR_W(AW), .DATA_W(DW), .BCNT_W(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_write(cmd_write),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
        .m_address(m_address), .m_burstcount(m_burstcount), .m_read(m_read),
        .m_write(m_write), .m_writedata(m_writedata), .m_byteenable(m_byteenable),
        .m_waitrequest(m_waitrequest), .m_readdata(m_readdata),
        .m_readdatavalid(m_readdatavalid)
    );

    function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a, input int i);
        return DW'(a * 13 + i * 257 + 16'h3C1);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic issue(input logic [AW-1:0] a, input logic [BW-1:0] n, input bit w);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = a; cmd_len = n; cmd_write = w;
        #1 chk(cmd_ready, "R2 ready before command", cmd_ready, 1);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic run_write(input logic [AW-1:0] a, input int n, input int gap_pct, input int wait_pct);
        int src_i = 0, acc_i = 0;
        bit prev_hold = 0, exp_gap = 0, exp_done = 0, seen = 0;
        logic [DW-1:0] prev_data = '0;
        issue(a, BW'(n), 1'b1);
        for (int cyc = 0; cyc < 500 && !seen; cyc++) begin
            if (cyc > 0) @(negedge clk);
            wr_valid = (src_i < n) && ($urandom_range(99) >= 32'(gap_pct));
            wr_data = word_of(a, src_i);
            m_waitrequest = ($urandom_range(99) < 32'(wait_pct));
            #1;
            if (prev_hold) chk(m_write && m_writedata == prev_data, "R3 write held", m_writedata, prev_data);
            if (exp_gap) chk(!m_write, "R5 gap on missing word", m_write, 0);
            chk(done == exp_done, "R7 write done timing", done, exp_done);
            chk(cmd_ready == exp_done, "R2 busy during burst", cmd_ready, exp_done);
            if (exp_done) seen = 1;
            if (m_write && m_waitrequest) chk(!wr_ready, "R4 no take while stalled", wr_ready, 0);
            if (m_write) begin
                chk(m_byteenable == '1, "R6 lanes", m_byteenable, 3);
                chk(m_address == a && m_burstcount == BW'(n), "R2 address", m_address, a);
                if (n == 8) chk(m_burstcount == 4'b1000, "R11 top-bit count", m_burstcount, 8);
            end
            exp_done = 0;
            if (m_write && !m_waitrequest) begin
                chk(m_writedata == word_of(a, acc_i), "R4 beat order", m_writedata, word_of(a, acc_i));
                acc_i++;
                exp_done = (acc_i == n);
            end
            prev_hold = m_write && m_waitrequest;
            prev_data = m_writedata;
            exp_gap = (!m_write || !m_waitrequest) && !wr_valid;
            if (wr_valid && wr_ready) src_i++;
        end
        wr_valid = 1'b0; m_waitrequest = 1'b0;
        chk(seen, "R7 write done seen", seen, 1);
        chk(acc_i == n, "R4 beat total", acc_i, n);
        @(negedge clk); #1 chk(!done && !m_write, "R7 single pulse", done, 0);
    endtask

    task automatic run_read(input logic [AW-1:0] a, input int n, input int gap_pct, input int wait_pct);
        int sent = 0;
        bit acc = 0, prev_v = 0, exp_done = 0, seen = 0;
        logic [DW-1:0] prev_d = '0;
        issue(a, BW'(n), 1'b0);
        for (int cyc = 0; cyc < 500 && !seen; cyc++) begin
            if (cyc > 0) @(negedge clk);
            m_waitrequest = !acc && ($urandom_range(99) < 32'(wait_pct));
            m_readdatavalid = acc && (sent < n) && ($urandom_range(99) >= 32'(gap_pct));
            m_readdata = m_readdatavalid ? word_of(a, sent) : 16'hDEAD;
            #1;
            chk(rd_valid == prev_v, "R8 read valid", rd_valid, prev_v);
            if (prev_v) chk(rd_data == prev_d, "R8 read data", rd_data, prev_d);
            chk(done == exp_done, "R7 read done timing", done, exp_done);
            chk(cmd_ready == exp_done, "R2 busy during burst", cmd_ready, exp_done);
            if (exp_done) seen = 1;
            chk(m_read == !acc, "R8 request held then dropped", m_read, !acc);
            if (m_read) begin
                chk(m_byteenable == '1, "R6 lanes", m_byteenable, 3);
                chk(m_address == a && m_burstcount == BW'(n), "R2 address", m_address, a);
                if (n == 8) chk(m_burstcount == 4'b1000, "R11 top-bit count", m_burstcount, 8);
            end
            if (m_read && !m_waitrequest) acc = 1;
            exp_done = m_readdatavalid && (sent == n - 1);
            prev_v = m_readdatavalid;
            prev_d = m_readdata;
            if (m_readdatavalid) sent++;
        end
        m_readdatavalid = 1'b0; m_waitrequest = 1'b0;
        chk(seen, "R7 read done seen", seen, 1);
        @(negedge clk); #1 chk(!done && !rd_valid, "R7 single pulse", done, 0);
    endtask

    task automatic run_illegal(input logic [BW-1:0] n);
        issue(12'h0F0, n, 1'b1);
        for (int k = 0; k < 4; k++) begin
            #1 chk(cmd_ready && !m_write && !m_read && !done, "R10 illegal length dropped",
                   {m_write, m_read, done}, 0);
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        #1 chk(cmd_ready && !m_read && !m_write && !done && !rd_valid, "R1 reset state",
               {cmd_ready, m_read, m_write, done, rd_valid}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed corners
        run_write(12'h100, 1, 0, 0);
        run_write(12'h200, 8, 0, 50);
        run_write(12'h300, 5, 60, 20);
        run_read(12'h400, 1, 0, 0);
        run_read(12'h500, 8, 40, 50);
        run_illegal(4'd0);
        run_illegal(4'd9);
        // R9: stray read data while idle
        @(negedge clk);
        m_readdatavalid = 1'b1; m_readdata = 16'hBEEF;
        @(negedge clk);
        m_readdatavalid = 1'b0;
        #1 chk(!rd_valid, "R9 stray beat ignored", rd_valid, 0);
        // Random bursts
        for (int b = 0; b < 60; b++) begin
            int n = int'($urandom_range(8, 1));
            logic [AW-1:0] a = AW'($urandom);
            if ($urandom_range(1) == 1)
                run_write(a, n, int'($urandom_range(70)), int'($urandom_range(70)));
            else
                run_read(a, n, int'($urandom_range(70)), int'($urandom_range(70)));
        end
        report();
    end
endmodule